// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-mapped watchdog for a system controller. A 12-bit counter counts down once per tick. A free-running divider makes one tick every `PRESCALE` clock cycles, which is 128 by default. Software must restart the counter before it passes zero. A restart is accepted only once the counter has fallen into a window whose upper bound is programmable. A restart that comes too early is treated as a failure, in the same way as an expiry.

Software sets the block up with a single write to a configuration register. That write sets the reload value, the window bound, what a fault does and whether counting pauses while the core is halted for debug or sleeping. After that first write the configuration is frozen until the next reset. A fault can raise a level interrupt, send a one-cycle request for a full system reset, or send a one-cycle request for a reset of the processor only. Reading the status register clears the fault flags.

Top module: `wdt_window`

## Requirements
- R1: While counting is enabled and not paused, the counter decreases by exactly one on every tick, and a tick occurs once every `PRESCALE` clock cycles.
- R2: Only the first write to the configuration register after reset takes effect. Every later write leaves it unchanged.
- R3: Registers sit at byte offsets 0x0 (control), 0x4 (configuration) and 0x8 (status), decoded from `bus_addr[3:2]`. The configuration register resets to 0x3FFF2FFF, and its bits 31:30 always read zero.
- R4: When a tick arrives with the counter at zero, status bit 0 (expiry) is set and the counter reloads from configuration bits 11:0. The counter value is visible in status bits 27:16.
- R5: A control write with 0xA5 in bits 31:24 and bit 0 set is a restart. A legal restart loads the counter from configuration bits 11:0. A control write with any other key does nothing.
- R6: A restart is legal only when the counter is less than or equal to the window bound in configuration bits 27:16. Otherwise status bit 1 (early restart) is set and the counter is not reloaded.
- R7: With configuration bit 15 (disable) set, the counter holds its value, restarts are ignored and no fault is flagged.
- R8: `irq` is high while configuration bit 12 is set and either status flag is set. A status read clears both flags, and so also drops `irq`, unless a new fault occurs in the same cycle.
- R9: On each fault, if configuration bit 13 is set, a one-cycle pulse appears on `cpu_rst_req` when bit 14 is set and on `sys_rst_req` otherwise. When bit 13 is clear, neither output pulses.
- R10: Counting pauses while configuration bit 28 is set and `dbg_halt` is high, and while bit 29 is set and `cpu_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status flags on a status read) |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dbg_halt | input | 1 | Core is halted for debug |
| cpu_idle | input | 1 | Core is idle |
| irq | output | 1 | Fault interrupt, level |
| sys_rst_req | output | 1 | One-cycle full reset request |
| cpu_rst_req | output | 1 | One-cycle processor-only reset request |

## Verification
The bench pauses the counter with the debug input so it can read exact values. It then checks the window edge at both sides. A restart at bound+1 must fault and leave the count alone, while a restart at exactly the bound must reload. A comparison that is off by one would move the fault to the wrong side of that edge. The bench sets up a single tick out of zero and checks that it yields both the expiry flag and a reload, not a wrap to 0xFFF. It also counts ticks over a fixed number of unpaused cycles to catch a wrong divider. Separate resets exercise the disable, processor-only and no-reset configurations, so a design that let a second configuration write through, or sent a reset pulse on the wrong output, would fail a check.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int PRESCALE = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_halt,
  input  logic        cpu_idle,
  output logic        irq,
  output logic        sys_rst_req,
  output logic        cpu_rst_req
);
  localparam int CW   = 12;
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
  localparam logic [29:0] CFG_RST = 30'h3FFF2FFF;
  localparam logic [7:0]  KEY     = 8'hA5;
  localparam int B_IRQ = 12, B_RST = 13, B_CPU = 14, B_DIS = 15, B_DBG = 28, B_IDLE = 29;

  logic [PS_W-1:0] ps;
  logic [29:0]     cfg;
  logic            locked;
  logic [CW-1:0]   cnt;
  logic [1:0]      flags;
  logic            fault_q;

  wire sel_ctl = bus_addr[3:2] == 2'd0;
  wire sel_cfg = bus_addr[3:2] == 2'd1;
  wire sel_sts = bus_addr[3:2] == 2'd2;

  wire [CW-1:0] reload = cfg[11:0];
  wire [CW-1:0] window = cfg[27:16];
  wire tick   = ps == PS_LAST;
  wire run    = !cfg[B_DIS] && !(cfg[B_DBG] && dbg_halt) && !(cfg[B_IDLE] && cpu_idle);
  wire kick   = bus_wr && sel_ctl && bus_wdata[31:24] == KEY && bus_wdata[0] && !cfg[B_DIS];
  wire early  = kick && (cnt > window);
  wire legal  = kick && !early;
  wire expire = tick && run && cnt == '0;
  wire rd_sts = bus_rd && sel_sts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ps <= '0;
    else        ps <= tick ? '0 : ps + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg    <= CFG_RST;
      locked <= 1'b0;
    end else if (bus_wr && sel_cfg && !locked) begin
      cfg    <= bus_wdata[29:0];
      locked <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt <= '1;
    else if (legal)          cnt <= reload;
    else if (tick && run)    cnt <= (cnt == '0) ? reload : cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags   <= '0;
      fault_q <= 1'b0;
    end else begin
      flags   <= (rd_sts ? 2'b00 : flags) | {early, expire};
      fault_q <= early || expire;
    end

  assign irq         = cfg[B_IRQ] && (flags != 2'b00);
  assign sys_rst_req = fault_q && cfg[B_RST] && !cfg[B_CPU];
  assign cpu_rst_req = fault_q && cfg[B_RST] && cfg[B_CPU];

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg)      bus_rdata = {2'b00, cfg};
    else if (sel_sts) bus_rdata = {4'b0000, cnt, 14'b0, flags};
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == reload));
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg));
  assert_expire_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(cnt) == '0);
  assert_early_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(bus_wr));
  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_DIS] && locked && !bus_wr) |=> $stable(cnt));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !early && !expire) |=> flags == 2'b00);
  assert_one_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && cpu_rst_req));
  assert_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_DBG] && dbg_halt && !bus_wr) |=> $stable(cnt));
endmodule

// File: tb/wdt_window_tb.sv
module wdt_window_tb;
  localparam int PS = 4;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, dbg_halt = 0, cpu_idle = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, sys_rst_req, cpu_rst_req;
  int n_chk = 0, n_bad = 0, n_sys = 0, n_cpu = 0;
  logic [31:0] d, c0;

  always #2 clk = ~clk;

  wdt_window #(.PRESCALE(PS)) u_dut (.*);

  always @(negedge clk) begin
    if (sys_rst_req) n_sys++;
    if (cpu_rst_req) n_cpu++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    n_sys = 0; n_cpu = 0;
  endtask

  task automatic freeze_at(input logic [11:0] target);
    logic [31:0] s;
    forever begin
      dbg_halt = 1;
      rd(4'h8, s);
      if (s[27:16] == target) break;
      dbg_halt = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    rd(4'h4, d); chk("R3 cfg reset value", d, 32'h3FFF2FFF);
    rd(4'h8, d); chk("R8 flags after reset", {30'b0, d[1:0]}, 0);
    chk("R8 irq after reset", {31'b0, irq}, 0);

    wr(4'h4, 32'h30083014);
    rd(4'h4, d); chk("R2 first cfg write", d, 32'h30083014);
    wr(4'h4, 32'h00000FFF);
    rd(4'h4, d); chk("R2 second cfg write ignored", d, 32'h30083014);

    wr(4'h0, 32'h5A000001);
    rd(4'h8, d); chk("R5 wrong key no fault", {30'b0, d[1:0]}, 0);
    chk("R5 wrong key no reload", {31'b0, d[27:16] >= 12'hF00}, 1);

    wr(4'h0, 32'hA5000001);
    @(negedge clk);
    chk("R9 sys pulse on early", n_sys, 1);
    chk("R8 irq on early", {31'b0, irq}, 1);
    rd(4'h8, d); chk("R6 early flag", {30'b0, d[1:0]}, 2);
    chk("R6 early no reload", {31'b0, d[27:16] >= 12'hF00}, 1);
    chk("R8 irq cleared by read", {31'b0, irq}, 0);

    freeze_at(12'd9);
    wr(4'h0, 32'hA5000001);
    rd(4'h8, d); chk("R6 restart at bound+1 flag", {30'b0, d[1:0]}, 2);
    chk("R6 restart at bound+1 count", {20'b0, d[27:16]}, 9);
    chk("R9 sys pulse count", n_sys, 2);
    dbg_halt = 0; @(negedge clk);

    freeze_at(12'd8);
    wr(4'h0, 32'hA5000001);
    rd(4'h8, d); chk("R6 restart at bound legal", {30'b0, d[1:0]}, 0);
    chk("R5 restart reloads", {20'b0, d[27:16]}, 20);
    chk("R9 no pulse on legal restart", n_sys, 2);

    repeat (40) @(negedge clk);
    rd(4'h8, d); chk("R10 debug pause", {20'b0, d[27:16]}, 20);
    dbg_halt = 0; cpu_idle = 1;
    repeat (40) @(negedge clk);
    rd(4'h8, d); chk("R10 idle pause", {20'b0, d[27:16]}, 20);
    cpu_idle = 0; dbg_halt = 1; @(negedge clk);

    dbg_halt = 0;
    repeat (8 * PS) @(negedge clk);
    dbg_halt = 1;
    rd(4'h8, d); chk("R1 eight ticks", {20'b0, d[27:16]}, 12);

    freeze_at(12'd0);
    dbg_halt = 0;
    repeat (PS) @(negedge clk);
    dbg_halt = 1;
    @(negedge clk);
    chk("R8 irq on expiry", {31'b0, irq}, 1);
    rd(4'h8, d); chk("R4 expiry flag", {30'b0, d[1:0]}, 1);
    chk("R4 reload after expiry", {20'b0, d[27:16]}, 20);
    chk("R9 sys pulse on expiry", n_sys, 3);
    chk("R9 no cpu pulse", n_cpu, 0);
    dbg_halt = 0;

    do_reset();
    wr(4'h4, 32'h0008B014);
    rd(4'h8, c0);
    repeat (40) @(negedge clk);
    rd(4'h8, d); chk("R7 disabled counter holds", {20'b0, d[27:16]}, {20'b0, c0[27:16]});
    wr(4'h0, 32'hA5000001);
    @(negedge clk);
    chk("R7 no irq when disabled", {31'b0, irq}, 0);
    rd(4'h8, d); chk("R7 no flag when disabled", {30'b0, d[1:0]}, 0);
    chk("R7 restart ignored", {20'b0, d[27:16]}, {20'b0, c0[27:16]});
    chk("R7 no reset pulse", n_sys + n_cpu, 0);

    do_reset();
    wr(4'h4, 32'hC0086014);
    rd(4'h4, d); chk("R3 top bits read zero", d, 32'h00086014);
    wr(4'h0, 32'hA5000001);
    @(negedge clk);
    chk("R9 cpu pulse", n_cpu, 1);
    chk("R9 no sys pulse", n_sys, 0);
    chk("R8 irq masked", {31'b0, irq}, 0);
    rd(4'h8, d); chk("R6 flag with irq masked", {30'b0, d[1:0]}, 2);

    do_reset();
    wr(4'h4, 32'h00081014);
    wr(4'h0, 32'hA5000001);
    @(negedge clk);
    chk("R8 irq without reset enable", {31'b0, irq}, 1);
    chk("R9 no pulses without reset enable", n_sys + n_cpu, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule